// File: doc/BRIEF.md
# Reloading Up-Timer with Sixteen-Level Pulse Output

This block is a 16-bit timer that counts upward from a value written by software. When the count reaches all ones, the next enabled tick puts the stored start value back into the counter. The same tick raises a one-cycle interrupt request for an external interrupt controller. The time between interrupts is therefore 0x10000 minus the start value, measured in enabled ticks.

Two free-running enable strobes drive the counter: a fast one and a slow one. A control register chooses which of the two take part. A strobe that takes part is ANDed into the count enable. A strobe that does not take part drops out of the AND. If neither takes part, the counter stops.

The stream of overflows also drives a pulse output. Sixteen overflows form one frame. The output is high during the first D overflow periods of each frame, where D is a 4-bit duty value. This gives duty levels from 0/16 to 15/16.

Top module: `uptimer_pwm`

## Requirements
- R1: After synchronous reset the count is 0x0000, the interrupt request and the pulse output are low, and both strobes are blocked, so the timer is halted.
- R2: A write to address 0 stores the start value and loads it into the counter at the same clock edge. It overrides any tick in that cycle, and no interrupt is raised for that cycle.
- R3: An enabled tick while the count is below 0xFFFF raises the count by exactly one.
- R4: An enabled tick while the count is 0xFFFF reloads the stored start value. The interrupt request is then high for exactly the one clock cycle after that edge.
- R5: Control bit 0 lets the fast strobe take part and bit 1 lets the slow strobe take part. The enable is the AND of the strobes that take part. A strobe that does not take part has no effect.
- R6: With both control bits 0, or when the strobes that take part are not all high, the count holds and no interrupt is raised.
- R7: The duty value is in control bits 9 to 6. Overflow periods are numbered 0 to 15 within each frame, starting from 0 at reset. The pulse output is high while that number is below the duty value.
- R8: A duty value of 0 holds the pulse output low at all times.
- R9: A duty value of 15 keeps the output high for 15 of every 16 overflow periods.
- R10: A write to address 1 (control) leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_fast | input | 1 | Fast enable strobe |
| tick_slow | input | 1 | Slow enable strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = start value, 1 = control |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| irq | output | 1 | One-cycle overflow interrupt request |
| pwm_out | output | 1 | Duty-controlled pulse output |

## Verification
A start value of 0xFFF0 gives short overflow periods, so the reload edge is reached many times. A design that fired one tick early or late, or reloaded zero, would show a wrong count right after each wrap. A start-value write arrives on the same cycle as a live tick; a design that let the tick win would show an extra increment. The strobe mix is driven through every combination of take-part bits. A design that ORed the strobes, or let a blocked strobe stall counting, would count on the wrong cycles. A start value of 0xFFFF gives an overflow on every tick, which runs full PWM frames quickly at duty values 3, 15 and 0. An off-by-one in the frame compare, or a duty-zero glitch, shows up as a wrong output level.

// File: rtl/uptimer_pkg.sv
package uptimer_pkg;

    localparam int CNT_W    = 16;
    localparam int DUTY_W   = 4;
    localparam int DUTY_LSB = 6;
    localparam int FRAME_W  = DUTY_W;

    localparam logic ADDR_START = 1'b0;
    localparam logic ADDR_CTRL  = 1'b1;

    typedef struct packed {
        logic [DUTY_W-1:0] duty;
        logic              use_slow;
        logic              use_fast;
    } ctrl_t;

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] value;
    } load_t;

    function automatic ctrl_t decode_ctrl(input logic [CNT_W-1:0] d);
        ctrl_t c;
        c.use_fast = d[0];
        c.use_slow = d[1];
        c.duty     = d[DUTY_LSB +: DUTY_W];
        return c;
    endfunction

    // a strobe that takes part must be high; one that does not is ignored
    function automatic logic strobe_ok(input logic take_part, input logic strobe);
        return ~take_part | strobe;
    endfunction

endpackage

// File: rtl/utp_regs.sv
module utp_regs
    import uptimer_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         wr_addr,
    input  logic [W-1:0] wr_data,
    output ctrl_t        ctrl_q,
    output logic [W-1:0] start_q,
    output load_t        ld
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            start_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CTRL) ctrl_q <= decode_ctrl(wr_data);
            else                      start_q <= wr_data;
        end
    end

    always_comb begin
        ld.valid = wr_en && (wr_addr == ADDR_START);
        ld.value = wr_data;
    end

endmodule

// File: rtl/utp_tick_gate.sv
module utp_tick_gate
    import uptimer_pkg::*;
#(
    parameter int NSRC = 2
) (
    input  ctrl_t     ctrl_q,
    input  logic      tick_fast,
    input  logic      tick_slow,
    output logic      tick_en
);

    logic [NSRC-1:0] take_part;
    logic [NSRC-1:0] strobe;
    logic [NSRC-1:0] ok;

    assign take_part = {ctrl_q.use_slow, ctrl_q.use_fast};
    assign strobe    = {tick_slow, tick_fast};

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign ok[i] = strobe_ok(take_part[i], strobe[i]);
    end

    assign tick_en = (|take_part) & (&ok);

endmodule

// File: rtl/utp_counter.sv
module utp_counter
    import uptimer_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_en,
    input  load_t        ld,
    input  logic [W-1:0] start_q,
    output logic [W-1:0] count,
    output logic         ovf,
    output logic         irq
);

    localparam logic [W-1:0] TOP = '1;

    assign ovf = tick_en && !ld.valid && (count == TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= ovf;
            if (ld.valid)     count <= ld.value[W-1:0];
            else if (ovf)     count <= start_q;
            else if (tick_en) count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/utp_pwm.sv
module utp_pwm
    import uptimer_pkg::*;
#(
    parameter int FW = FRAME_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ovf,
    input  logic [FW-1:0] duty,
    output logic          pwm_out
);

    logic [FW-1:0] slot;

    always_ff @(posedge clk) begin
        if (rst)      slot <= '0;
        else if (ovf) slot <= slot + 1'b1;
    end

    assign pwm_out = (slot < duty);

endmodule

// File: rtl/uptimer_pwm.sv
module uptimer_pwm
    import uptimer_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_fast,
    input  logic         tick_slow,
    input  logic         wr_en,
    input  logic         wr_addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] count,
    output logic         irq,
    output logic         pwm_out
);

    ctrl_t        ctrl_q;
    logic [W-1:0] start_q;
    load_t        ld;
    logic         tick_en;
    logic         ovf;

    utp_regs #(.W(W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl_q(ctrl_q), .start_q(start_q), .ld(ld)
    );

    utp_tick_gate u_gate (
        .ctrl_q(ctrl_q), .tick_fast(tick_fast), .tick_slow(tick_slow),
        .tick_en(tick_en)
    );

    utp_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .tick_en(tick_en), .ld(ld),
        .start_q(start_q), .count(count), .ovf(ovf), .irq(irq)
    );

    utp_pwm #(.FW(FRAME_W)) u_pwm (
        .clk(clk), .rst(rst), .ovf(ovf), .duty(ctrl_q.duty), .pwm_out(pwm_out)
    );

endmodule

// File: rtl/uptimer_pwm_chk.sv
module uptimer_pwm_chk
    import uptimer_pkg::*;
#(
    parameter int W = CNT_W
) (
    input logic         clk,
    input logic         rst,
    input logic         wr_en,
    input logic         wr_addr,
    input logic [W-1:0] wr_data,
    input logic         tick_en,
    input ctrl_t        ctrl_q,
    input logic [W-1:0] start_q,
    input logic [W-1:0] count,
    input logic         irq,
    input logic         pwm_out
);

    localparam logic [W-1:0] TOP = '1;

    logic past_ok;
    logic wr_start;

    always_ff @(posedge clk) begin
        if (rst) past_ok <= 1'b0;
        else     past_ok <= 1'b1;
    end

    assign wr_start = wr_en && (wr_addr == ADDR_START);

    a_r2_load_now: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $past(wr_start) |-> (count == $past(wr_data) && !irq));

    a_r3_step_one: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $past(tick_en && !wr_start && count != TOP) |-> (count == W'($past(count) + 1'b1)));

    a_r4_wrap_reload: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $past(tick_en && !wr_start && count == TOP) |-> (irq && count == $past(start_q)));

    a_r4_irq_cause: assert property (@(posedge clk) disable iff (rst || !past_ok)
        irq |-> ($past(tick_en) && $past(count) == TOP));

    a_r5_none_halts: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.use_fast && !ctrl_q.use_slow) |-> !tick_en);

    a_r6_hold: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $past(!tick_en && !wr_start) |-> ($stable(count) && !irq));

    a_r8_duty_zero: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.duty == '0) |-> !pwm_out);

endmodule

bind uptimer_pwm uptimer_pwm_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick_en(tick_en), .ctrl_q(ctrl_q), .start_q(start_q), .count(count),
    .irq(irq), .pwm_out(pwm_out)
);

// File: tb/sim_uptimer_pwm.sv
`timescale 1ns/1ps
module sim_uptimer_pwm;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_fast = 1'b0, tick_slow = 1'b0;
    logic        wr_en = 1'b0, wr_addr = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] count;
    logic        irq, pwm_out;

    always #2 clk = ~clk;   // 250 MHz

    uptimer_pwm u0 (
        .clk(clk), .rst(rst), .tick_fast(tick_fast), .tick_slow(tick_slow),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .count(count), .irq(irq), .pwm_out(pwm_out)
    );

    typedef struct {
        string       tag;
        logic [15:0] cnt;
        logic        irq;
        logic        pwm;
    } exp_t;

    exp_t q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // reference state, built from the requirements
    logic [15:0] m_cnt = '0, m_start = '0, m_ctrl = '0;
    logic [3:0]  m_slot = '0;
    logic        m_irq = 1'b0;

    task automatic cyc(input logic w, input logic ad, input logic [15:0] d,
                       input logic a, input logic b, input string tag);
        logic fa, sb, en;
        exp_t e;
        @(negedge clk);
        wr_en = w; wr_addr = ad; wr_data = d; tick_fast = a; tick_slow = b;
        fa = m_ctrl[0]; sb = m_ctrl[1];
        en = (fa | sb) & (~fa | a) & (~sb | b);
        m_irq = 1'b0;
        if (w && ad == 1'b0) begin
            m_start = d; m_cnt = d;
        end else if (en) begin
            if (m_cnt == 16'hFFFF) begin
                m_cnt = m_start; m_irq = 1'b1; m_slot = m_slot + 4'd1;
            end else begin
                m_cnt = m_cnt + 16'd1;
            end
        end
        if (w && ad == 1'b1) m_ctrl = d;
        e.tag = tag; e.cnt = m_cnt; e.irq = m_irq;
        e.pwm = (m_slot < m_ctrl[9:6]);
        q.push_back(e);
    endtask

    function automatic logic [15:0] ctrl_word(input int duty, input int sel);
        return 16'((duty << 6) | sel);
    endfunction

    // monitor: compare after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_run++;
                if (count !== e.cnt || irq !== e.irq || pwm_out !== e.pwm) begin
                    n_fail++;
                    $display("FAIL %s: count=%h irq=%b pwm=%b expected count=%h irq=%b pwm=%b",
                             e.tag, count, irq, pwm_out, e.cnt, e.irq, e.pwm);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state, halted
        repeat (2) cyc(0, 0, 16'h0, 0, 0, "R1");
        // R6: both strobes blocked, strobes high, count holds
        repeat (4) cyc(0, 0, 16'h0, 1, 1, "R6");
        // R10: control write keeps count
        cyc(1, 1, ctrl_word(3, 1), 1, 1, "R10");
        cyc(0, 0, 16'h0, 0, 0, "R10");
        // R2: start write beats a live tick
        cyc(1, 0, 16'hFFF0, 1, 0, "R2");
        // R3: increments
        repeat (10) cyc(0, 0, 16'h0, 1, 0, "R3");
        // R4: wraps and reloads
        repeat (40) cyc(0, 0, 16'h0, 1, 0, "R4");
        // R5: slow strobe only takes part
        cyc(1, 1, ctrl_word(3, 2), 0, 0, "R5");
        repeat (4) cyc(0, 0, 16'h0, 1, 0, "R5");
        repeat (6) cyc(0, 0, 16'h0, 0, 1, "R5");
        // R5: both take part
        cyc(1, 1, ctrl_word(3, 3), 0, 0, "R5");
        repeat (3) cyc(0, 0, 16'h0, 1, 0, "R5");
        repeat (3) cyc(0, 0, 16'h0, 0, 1, "R5");
        repeat (20) cyc(0, 0, 16'h0, 1, 1, "R5");
        // R6: taking-part strobe low
        repeat (4) cyc(0, 0, 16'h0, 0, 0, "R6");
        // R2: mid-run start write with tick present
        cyc(1, 0, 16'h1234, 1, 1, "R2");
        cyc(0, 0, 16'h0, 1, 1, "R2");
        // R7: overflow every tick, duty 3
        cyc(1, 1, ctrl_word(3, 1), 0, 0, "R7");
        cyc(1, 0, 16'hFFFF, 0, 0, "R7");
        repeat (48) cyc(0, 0, 16'h0, 1, 0, "R7");
        // R9: duty 15
        cyc(1, 1, ctrl_word(15, 1), 0, 0, "R9");
        repeat (40) cyc(0, 0, 16'h0, 1, 0, "R9");
        // R8: duty 0
        cyc(1, 1, ctrl_word(0, 1), 0, 0, "R8");
        repeat (40) cyc(0, 0, 16'h0, 1, 0, "R8");
        cyc(0, 0, 16'h0, 0, 0, "R8");
        repeat (4) @(posedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule